// File: doc/BRIEF.md
# Linked-Descriptor Memory-to-Stream Mover

This block is the transmit side of one DMA channel. Software places a chain of four-word data descriptors in memory and starts the engine with two pointers: the first data descriptor and a context descriptor. The engine fetches each descriptor and reads its buffer from a 32-bit word memory port. It sends the buffer out one byte per beat on a valid/ready stream, with a last marker and a metadata sideband. When a buffer is finished, the engine writes the descriptor back to memory. It follows the next pointer until it reaches a descriptor that marks the end of the list.

At the end of the list, the engine sets the disable bit in the context descriptor's flag word. It then raises its end-of-list status and stays quiet until the next start. Descriptors that request it produce a one-cycle data interrupt pulse, which a surrounding register block can fold into its raw interrupt state.

Top module: `dsd_stream_dma`

## Requirements
- R1: After reset the block is idle: no memory request, no stream or metadata beat, end-of-list and busy low.
- R2: A start pulse while idle reads the descriptor at the start pointer as four words, at byte offsets 0, 4, 8 and 12, in that order. Word 0 holds the next pointer, word 1 the buffer start, word 2 the flags and word 3 the exclusive buffer end.
- R3: The bytes from buffer start up to buffer end minus one leave in ascending address order. The byte at address a is bits [8*(a mod 4)+7 : 8*(a mod 4)] of the memory word at a with its two low bits cleared.
- R4: The last marker is high only on the final byte of a buffer, and only when flag bit 3 (packet end) of that descriptor is set.
- R5: Flag bits [31:16] of a descriptor are offered once on the metadata channel before its data, when the descriptor is the first of the chain or follows a descriptor that had flag bit 3 set. At no other time are they offered.
- R6: A stream or metadata beat stays stable while ready is low. The buffer pointer moves only on accepted beats, so no byte is lost or repeated.
- R7: A finished descriptor is written back as four unchanged words at its own address, each word exactly once.
- R8: When a finished descriptor has flag bit 4 set, the interrupt output pulses high for one cycle after its write-back. Otherwise there is no pulse.
- R9: If flag bit 0 (end of list) is set, the engine reads the context flag word at context pointer plus 4, writes it back with bit 15 set, raises end-of-list and goes idle. Otherwise it fetches the descriptor at the next pointer.
- R10: While end-of-list is high the block makes no memory request and no beat. A start pulse while busy is ignored.
- R11: A descriptor whose buffer end equals its buffer start produces no data beat but is still written back and still follows R5, R8 and R9.
- R12: A memory request holds its address, direction and write data until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| dscr_ptr_i | input | 32 | Address of first data descriptor |
| ctx_ptr_i | input | 32 | Address of context descriptor |
| busy_o | output | 1 | Engine is walking a chain |
| eol_o | output | 1 | Chain finished, held until next start |
| data_irq_o | output | 1 | One-cycle data interrupt pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid, at least one cycle after grant |
| mem_rdata_i | input | 32 | Read data |
| m_valid_o | output | 1 | Stream byte valid |
| m_ready_i | input | 1 | Stream sink ready |
| m_data_o | output | 8 | Stream byte |
| m_last_o | output | 1 | Last byte of packet |
| md_valid_o | output | 1 | Metadata valid |
| md_ready_i | input | 1 | Metadata sink ready |
| md_data_o | output | 16 | Metadata word |

## Verification
The bench walks an unaligned buffer that spans word boundaries. A design with the wrong lane selection or word reload point would duplicate or reorder bytes. An empty descriptor sits in mid-chain; a design mishandling it would emit spurious bytes or skip its write-back. Packet-end flags are mixed so that a design re-sending metadata after every descriptor, or raising last without the flag, shows up in the scoreboard. Random ready and grant stalls catch lost or repeated bytes, and a start pulse mid-chain catches a design that restarts when it should not. The final context word catches a wrong disable bit or a wrong offset.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_META, S_LOAD, S_EMIT, S_WBACK, S_CTX_RD, S_CTX_WR
  } dsd_state_e;

  localparam int DSCR_WORDS  = 4;
  localparam int FLG_EOL     = 0;
  localparam int FLG_OEOP    = 3;
  localparam int FLG_INTR    = 4;
  localparam int FLG_MD_LSB  = 16;
  localparam int CTX_DIS_BIT = 15;
endpackage

// File: rtl/dsd_dscr_file.sv
module dsd_dscr_file #(
  parameter int W = 32,
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [W-1:0]      wdata_i,
  output logic [N-1:0][W-1:0] words_o
);
  for (genvar g = 0; g < N; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          words_o[g] <= '0;
      else if (wr_i && idx_i == IW'(g))     words_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/dsd_byte_pick.sv
module dsd_byte_pick #(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [LW-1:0]     sel_i,
  output logic [7:0]        byte_o
);
  logic [NB-1:0][7:0] lanes;
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = word_i[8*g +: 8];
  end
  assign byte_o = lanes[sel_i];
endmodule

// File: rtl/dsd_stream_dma.sv
module dsd_stream_dma
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MD_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dscr_ptr_i,
  input  logic [ADDR_W-1:0] ctx_ptr_i,
  output logic              busy_o,
  output logic              eol_o,
  output logic              data_irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [7:0]        m_data_o,
  output logic              m_last_o,
  output logic              md_valid_o,
  input  logic              md_ready_i,
  output logic [MD_W-1:0]   md_data_o
);
  localparam int BYTES = DATA_W / 8;
  localparam int LANE_W = $clog2(BYTES);
  localparam int IDX_W = $clog2(DSCR_WORDS);

  dsd_state_e               st_q;
  logic [ADDR_W-1:0]        dptr_q, ctx_q, cur_q;
  logic [DATA_W-1:0]        word_q;
  logic [IDX_W-1:0]         idx_q;
  logic                     pend_q, send_md_q, eol_q, irq_q;
  logic [DSCR_WORDS-1:0][DATA_W-1:0] dw;
  logic [ADDR_W-1:0]        nxt, bstart, bend;
  logic [DATA_W-1:0]        flg;
  logic                     rd_done, last_beat, dscr_wr;
  logic                     unused_flags;

  assign nxt    = ADDR_W'(dw[0]);
  assign bstart = ADDR_W'(dw[1]);
  assign flg    = dw[2];
  assign bend   = ADDR_W'(dw[3]);
  assign unused_flags = ^{flg[15:5], flg[2:1]};

  assign rd_done   = pend_q && mem_rvalid_i;
  assign last_beat = (cur_q + ADDR_W'(1)) == bend;
  assign dscr_wr   = (st_q == S_FETCH) && rd_done;

  dsd_dscr_file #(.W(DATA_W), .N(DSCR_WORDS)) u_dscr (
    .clk_i, .rst_ni,
    .wr_i    (dscr_wr),
    .idx_i   (idx_q),
    .wdata_i (mem_rdata_i),
    .words_o (dw)
  );

  dsd_byte_pick #(.DATA_W(DATA_W)) u_pick (
    .word_i (word_q),
    .sel_i  (cur_q[LANE_W-1:0]),
    .byte_o (m_data_o)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      S_FETCH: begin
        mem_req_o  = !pend_q;
        mem_addr_o = dptr_q + (ADDR_W'(idx_q) << LANE_W);
      end
      S_LOAD: begin
        mem_req_o  = !pend_q;
        mem_addr_o = {cur_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      end
      S_WBACK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dptr_q + (ADDR_W'(idx_q) << LANE_W);
        mem_wdata_o = dw[idx_q];
      end
      S_CTX_RD: begin
        mem_req_o  = !pend_q;
        mem_addr_o = ctx_q + ADDR_W'(BYTES);
      end
      S_CTX_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ctx_q + ADDR_W'(BYTES);
        mem_wdata_o = word_q | (DATA_W'(1) << CTX_DIS_BIT);
      end
      default: ;
    endcase
  end

  assign m_valid_o  = (st_q == S_EMIT);
  assign m_last_o   = (st_q == S_EMIT) && last_beat && flg[FLG_OEOP];
  assign md_valid_o = (st_q == S_META);
  assign md_data_o  = flg[FLG_MD_LSB +: MD_W];
  assign busy_o     = (st_q != S_IDLE);
  assign eol_o      = eol_q;
  assign data_irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      dptr_q    <= '0;
      ctx_q     <= '0;
      cur_q     <= '0;
      word_q    <= '0;
      idx_q     <= '0;
      pend_q    <= 1'b0;
      send_md_q <= 1'b0;
      eol_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (mem_req_o && mem_gnt_i && !mem_we_o) pend_q <= 1'b1;
      if (rd_done)                             pend_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          dptr_q    <= dscr_ptr_i;
          ctx_q     <= ctx_ptr_i;
          eol_q     <= 1'b0;
          send_md_q <= 1'b1;
          idx_q     <= '0;
          st_q      <= S_FETCH;
        end
        S_FETCH: if (rd_done) begin
          idx_q <= idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(DSCR_WORDS - 1)) begin
            cur_q <= bstart;
            if (send_md_q)                                st_q <= S_META;
            else if (bstart == ADDR_W'(mem_rdata_i))      st_q <= S_WBACK;
            else                                          st_q <= S_LOAD;
          end
        end
        S_META: if (md_ready_i) begin
          send_md_q <= 1'b0;
          st_q      <= (cur_q == bend) ? S_WBACK : S_LOAD;
        end
        S_LOAD: if (rd_done) begin
          word_q <= mem_rdata_i;
          st_q   <= S_EMIT;
        end
        S_EMIT: if (m_ready_i) begin
          cur_q <= cur_q + ADDR_W'(1);
          if (last_beat)                  st_q <= S_WBACK;
          else if (&cur_q[LANE_W-1:0])    st_q <= S_LOAD;
        end
        S_WBACK: if (mem_gnt_i) begin
          idx_q <= idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(DSCR_WORDS - 1)) begin
            irq_q <= flg[FLG_INTR];
            if (flg[FLG_OEOP]) send_md_q <= 1'b1;
            if (flg[FLG_EOL]) st_q <= S_CTX_RD;
            else begin
              dptr_q <= nxt;
              st_q   <= S_FETCH;
            end
          end
        end
        S_CTX_RD: if (rd_done) begin
          word_q <= mem_rdata_i;
          st_q   <= S_CTX_WR;
        end
        S_CTX_WR: if (mem_gnt_i) begin
          eol_q <= 1'b1;
          st_q  <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsd_stream_dma_chk.sv
module dsd_stream_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MD_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              m_valid_i,
  input logic              m_ready_i,
  input logic [7:0]        m_data_i,
  input logic              m_last_i,
  input logic              md_valid_i,
  input logic              md_ready_i,
  input logic [MD_W-1:0]   md_data_i,
  input logic              mem_req_i,
  input logic              mem_gnt_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [DATA_W-1:0] mem_wdata_i,
  input logic              eol_i,
  input logic              irq_i,
  input logic [ADDR_W-1:0] cur_i,
  input logic [ADDR_W-1:0] bend_i
);
  p_last_at_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_i && m_last_i |-> (cur_i + ADDR_W'(1)) == bend_i);

  p_beat_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_i && !m_ready_i |=> m_valid_i && $stable(m_data_i) && $stable(m_last_i));

  p_md_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    md_valid_i && !md_ready_i |=> md_valid_i && $stable(md_data_i));

  p_md_data_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(md_valid_i && m_valid_i));

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_gnt_i |=> mem_req_i && $stable(mem_addr_i) &&
                                $stable(mem_we_i) && $stable(mem_wdata_i));

  p_eol_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_i |-> !mem_req_i && !m_valid_i && !md_valid_i);

  p_irq_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);
endmodule

bind dsd_stream_dma dsd_stream_dma_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MD_W(MD_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .m_valid_i   (m_valid_o),
  .m_ready_i   (m_ready_i),
  .m_data_i    (m_data_o),
  .m_last_i    (m_last_o),
  .md_valid_i  (md_valid_o),
  .md_ready_i  (md_ready_i),
  .md_data_i   (md_data_o),
  .mem_req_i   (mem_req_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_we_i    (mem_we_o),
  .mem_addr_i  (mem_addr_o),
  .mem_wdata_i (mem_wdata_o),
  .eol_i       (eol_o),
  .irq_i       (data_irq_o),
  .cur_i       (cur_q),
  .bend_i      (bend)
);

// File: tb/dsd_stream_dma_bench.sv
`timescale 1ns/1ps
module dsd_stream_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dscr_ptr = '0, ctx_ptr = '0;
  logic        busy, eol, irq;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        m_valid, m_ready = 1'b0, m_last;
  logic [7:0]  m_data;
  logic        md_valid, md_ready = 1'b0;
  logic [15:0] md_data;

  always #2 clk = ~clk;

  dsd_stream_dma u_dsd_stream_dma (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dscr_ptr_i(dscr_ptr), .ctx_ptr_i(ctx_ptr),
    .busy_o(busy), .eol_o(eol), .data_irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data), .m_last_o(m_last),
    .md_valid_o(md_valid), .md_ready_i(md_ready), .md_data_o(md_data)
  );

  logic [31:0] mem [256];
  logic [31:0] shadow [256];
  int          wr_cnt [256];
  logic [8:0]  exp_q [$];
  logic [15:0] md_q [$];
  int checks = 0, fails = 0;
  int irq_seen = 0, beats = 0, req_seen = 0, hold_viol = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        rd_pend = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        want_first = 1'b0;
  logic [31:0] first_rd = '0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;
  logic        md_pending = 1'b0;
  int          irq_exp = 0;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: places a descriptor and queues what it must produce
  task automatic add_dscr(int base, int nxt, int bs, int flags, int be);
    mem[base/4] = 32'(nxt);   mem[base/4+1] = 32'(bs);
    mem[base/4+2] = 32'(flags); mem[base/4+3] = 32'(be);
    for (int k = 0; k < 4; k++) shadow[base/4+k] = mem[base/4+k];
    if (md_pending) md_q.push_back(16'(flags >>> 16));
    for (int a = bs; a < be; a++)
      exp_q.push_back({(a == be - 1) && flags[3], pat(a)});
    md_pending = flags[3];
    if (flags[4]) irq_exp++;
  endtask

  task automatic clear_counts();
    for (int k = 0; k < 256; k++) wr_cnt[k] = 0;
    irq_seen = 0; irq_exp = 0; md_pending = 1'b1;
  endtask

  task automatic pulse_start(int d, int c);
    @(negedge clk);
    dscr_ptr = 32'(d); ctx_ptr = 32'(c); start = 1'b1; want_first = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_eol();
    for (int n = 0; n < 20000 && !eol; n++) @(negedge clk);
  endtask

  task automatic check_dscr(int base, string req);
    for (int k = 0; k < 4; k++) begin
      chk(wr_cnt[base/4+k] == 1, req, 32'(wr_cnt[base/4+k]), 32'd1);
      chk(mem[base/4+k] == shadow[base/4+k], req, mem[base/4+k], shadow[base/4+k]);
    end
  endtask

  // bus model and monitor
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready  = lfsr[0] | lfsr[3];
    md_ready = lfsr[2] | lfsr[7];
    mem_gnt  = lfsr[1] | lfsr[5];
    mem_rvalid = rd_pend;
    if (rd_pend) mem_rdata = mem[rd_addr[9:2]];
    rd_pend = 1'b0;
    #1;
    if (rst_n) begin
      if (prev_wait && !(mem_req && mem_addr == prev_addr)) hold_viol++;
      prev_wait = mem_req && !mem_gnt;
      prev_addr = mem_addr;
      if (mem_req) req_seen++;
      if (irq) irq_seen++;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          mem[mem_addr[9:2]] = mem_wdata;
          wr_cnt[mem_addr[9:2]]++;
        end else begin
          rd_pend = 1'b1;
          rd_addr = mem_addr;
          if (want_first) begin first_rd = mem_addr; want_first = 1'b0; end
        end
      end
      if (m_valid && m_ready) begin
        beats++;
        if (exp_q.size() == 0) chk(0, "R3 unexpected byte", {23'd0, m_last, m_data}, 32'h0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(m_data == e[7:0], "R3/R6 byte", {24'd0, m_data}, {24'd0, e[7:0]});
          chk(m_last == e[8], "R4 last", {31'd0, m_last}, {31'd0, e[8]});
        end
      end
      if (md_valid && md_ready) begin
        if (md_q.size() == 0) chk(0, "R5 unexpected metadata", {16'd0, md_data}, 32'h0);
        else begin
          logic [15:0] e;
          e = md_q.pop_front();
          chk(md_data == e, "R5 metadata", {16'd0, md_data}, {16'd0, e});
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) begin
      mem[k] = {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)};
      shadow[k] = mem[k];
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !eol && !mem_req && !m_valid && !md_valid, "R1 reset",
        {28'd0, busy, eol, mem_req, m_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // chain A: unaligned buffer, empty descriptor, eop+intr mix
    clear_counts();
    mem[16'h0f4/4] = 32'h0000_0021;
    add_dscr(16'h000, 16'h010, 16'h101, 32'hA1B2_0018, 16'h107);
    add_dscr(16'h010, 16'h020, 16'h200, 32'h1111_0000, 16'h200);
    add_dscr(16'h020, 16'h000, 16'h203, 32'hC3D4_0019, 16'h20b);
    pulse_start(16'h000, 16'h0f0);
    wait_eol();
    repeat (3) @(negedge clk);
    chk(eol == 1'b1, "R9 eol raised", {31'd0, eol}, 32'd1);
    chk(first_rd == 32'h000, "R2 first fetch", first_rd, 32'h000);
    chk(exp_q.size() == 0, "R3 all bytes", 32'(exp_q.size()), 0);
    chk(md_q.size() == 0, "R5 all metadata", 32'(md_q.size()), 0);
    chk(irq_seen == irq_exp, "R8 irq pulses", 32'(irq_seen), 32'(irq_exp));
    chk(mem[16'h0f4/4] == 32'h0000_8021, "R9 context disable", mem[16'h0f4/4], 32'h0000_8021);
    chk(wr_cnt[16'h0f4/4] == 1, "R9 context written once", 32'(wr_cnt[16'h0f4/4]), 1);
    check_dscr(16'h000, "R7 writeback d0");
    check_dscr(16'h010, "R11 empty descriptor writeback");
    check_dscr(16'h020, "R7 writeback d2");

    // R10: quiet while end-of-list is held
    req_seen = 0; beats = 0;
    repeat (40) @(negedge clk);
    chk(req_seen == 0 && beats == 0, "R10 quiet after eol", 32'(req_seen + beats), 0);
    chk(eol == 1'b1, "R10 eol held", {31'd0, eol}, 32'd1);

    // chain B: no packet end, no interrupt, start pulsed while busy
    clear_counts();
    mem[16'h0e4/4] = 32'h0000_0003;
    add_dscr(16'h040, 16'h050, 16'h300, 32'h5555_0000, 16'h305);
    add_dscr(16'h050, 16'h040, 16'h310, 32'h6666_0001, 16'h312);
    beats = 0;
    pulse_start(16'h040, 16'h0e0);
    chk(eol == 1'b0, "R10 start clears eol", {31'd0, eol}, 32'd0);
    for (int n = 0; n < 5000 && beats == 0; n++) @(negedge clk);
    pulse_start(16'h000, 16'h0f0);
    wait_eol();
    repeat (3) @(negedge clk);
    chk(first_rd != 32'h000, "R10 start while busy ignored", first_rd, 32'h1);
    chk(exp_q.size() == 0, "R3 chain B bytes", 32'(exp_q.size()), 0);
    chk(md_q.size() == 0, "R5 chain B metadata", 32'(md_q.size()), 0);
    chk(irq_seen == 0, "R8 no irq without flag", 32'(irq_seen), 0);
    chk(mem[16'h0e4/4] == 32'h0000_8003, "R9 context B", mem[16'h0e4/4], 32'h0000_8003);
    check_dscr(16'h040, "R7 writeback B0");
    check_dscr(16'h050, "R7 writeback B1");
    chk(hold_viol == 0, "R12 request hold", 32'(hold_viol), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule